// File: doc/BRIEF.md
# Seven-Way Translation Buffer with Ring-Tagged Address Spaces

This block is the translation buffer of a 32-bit memory management unit. It has seven ways with different page sizes. Ways 0 to 3 hold 4 KB refill pages. Way 4 holds pages whose size is set by a two-bit configuration input. Ways 5 and 6 are fixed: they hold four large, permanently mapped windows in the top quarter of the address space. A lookup is purely combinational. It takes a virtual address, the current privilege ring and an access kind, and in the same cycle it returns a hit, miss or multi-hit result, the ring of the matching entry, the physical address, the decoded read, write and execute permissions and a fault cause.

Each entry holds an address-space tag (ASID). An entry counts only when its tag is nonzero and also appears in one byte of a packed four-byte ring register. The position of that byte gives the ring of the entry. Maintenance goes through one command port, with a plain valid strobe and no back-pressure. A command is taken on every clock edge where `cmd_valid` is high. There are four commands: write an entry, invalidate an entry, read an entry back, and load the ring register. Entry commands address their target with one word. Bits 2:0 of that word select the way. The upper bits supply the page number, and from that page number the way derives its entry index.

Top module: `tlb_mmu`

## Requirements
- R1: After reset the ring register reads 0x04030201, every entry of ways 0 to 4 is invalid, and a lookup outside the fixed windows reports a miss (result 1, fault 1).
- R2: A ring-register command stores cmd_data with its low byte forced to 0x01. The new value is visible on `ring_asid` and in lookups from the next cycle on.
- R3: A way hits when its stored page number equals the address masked by the way's page mask, its tag is nonzero, and the tag equals one byte of the ring register. The lowest such byte position (0 to 3) is reported on `lk_ring`. When no byte matches, the entry does not hit.
- R4: Exactly one hitting way gives result 0 (hit). Two or more give result 2 with fault 2. None gives result 1 with fault 1. On a miss or a multi-hit, the ring, the physical address and the permissions read zero.
- R5: Page masks and indices work as follows. Ways 0 to 3 use mask 0xFFFFF000 and index bits 13:12, or bits 14:12 when REFILL_32 is set. Way 4 uses mask 0xFFF00000 shifted left by twice `cfg_way4_size`, with a 2-bit index just above the mask. Way 5 uses mask 0xF8000000 and index bit 27. Way 6 uses mask 0xF0000000 and index bit 28.
- R6: On a hit the physical address is the entry's physical page ORed with the virtual-address bits below the way's mask.
- R7: The fault code is 0 for none, 1 for miss, 2 for multi-hit, 3 for privilege and 4 for prohibited. These are checked in order: miss or multi-hit first, then privilege (entry ring lower than `lk_cur_ring`), then prohibited.
- R8: An attribute below 12 grants read, its bit 1 grants write and its bit 0 grants execute. Attribute 13 grants read and write and raises `lk_isolate`. Every other value grants nothing. The access codes are: 0 read, 1 write, 2 execute, and 3, which is never granted.
- R9: The write command (op 0) stores the following into the way selected by cmd_addr[2:0], at the index taken from cmd_addr: page number = cmd_addr & mask, physical page = cmd_data & mask, tag = byte cmd_data[5:4] of the ring register, attribute = cmd_data[3:0]. Ways 5, 6 and 7 ignore writes.
- R10: The invalidate command (op 1) clears the tag of the addressed entry in ways 0 to 4, so a later lookup of that page misses in that way. Fixed entries keep their contents.
- R11: The read command (op 2) raises `rd_valid` for one cycle, one cycle later. With it comes `rd_tag` = page number OR tag and `rd_word` = physical page OR attribute. Way 7 reads as zero.
- R12: After reset, way 5 maps 0xD0000000 to 0 with attribute 7 and 0xD8000000 to 0 with attribute 3. Way 6 maps 0xE0000000 to 0xF0000000 with attribute 7 and 0xF0000000 to 0xF0000000 with attribute 3. All four use tag 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_way4_size | input | 2 | Page-size selector of way 4 |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_cur_ring | input | 2 | Current privilege ring |
| lk_access | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| lk_result | output | 2 | 0 hit, 1 miss, 2 multi-hit |
| lk_fault | output | 3 | Fault cause code |
| lk_ring | output | 2 | Ring of the matching entry |
| lk_paddr | output | 32 | Physical address |
| lk_perm_r | output | 1 | Read permitted |
| lk_perm_w | output | 1 | Write permitted |
| lk_perm_x | output | 1 | Execute permitted |
| lk_isolate | output | 1 | Isolate-mode attribute |
| cmd_valid | input | 1 | Command strobe, taken on each edge while high |
| cmd_op | input | 2 | 0 write, 1 invalidate, 2 read, 3 load ring register |
| cmd_addr | input | 32 | Way in bits 2:0, page number above |
| cmd_data | input | 32 | Page-table word or ring-register value |
| rd_valid | output | 1 | Read-back data valid |
| rd_tag | output | 32 | Read-back page number OR tag |
| rd_word | output | 32 | Read-back physical page OR attribute |
| ring_asid | output | 32 | Ring register contents |

## Verification
The checker verifies the following on every cycle:
- the ring register's forced low byte and its update one cycle after a load;
- that the page offset passes through on a hit;
- the consistency of the fault codes with the result and ring;
- that write permission never appears without read;
- the one-cycle read-back strobe.

The bench scenarios alone cover the matters that depend on stored contents:
- the reset windows;
- tag capture through the ring byte;
- multi-hit between overlapping ways;
- invalidation;
- fixed entries ignoring writes;
- the way-4 page-size change.

A reference model in the bench checks these against random command streams.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int NUM_WAYS = 7;
  localparam int IDX_W    = 3;
  localparam int VA_W     = 32;
  localparam int ASID_W   = 8;
  localparam int ATTR_W   = 4;

  typedef enum logic [1:0] {RES_HIT = 2'd0, RES_MISS = 2'd1, RES_MULTI = 2'd2} tlb_res_e;
  typedef enum logic [2:0] {FLT_NONE = 3'd0, FLT_MISS = 3'd1, FLT_MULTI = 3'd2,
                            FLT_PRIV = 3'd3, FLT_PROHIB = 3'd4} tlb_flt_e;
  typedef enum logic [1:0] {OP_WRITE = 2'd0, OP_INVAL = 2'd1, OP_READ = 2'd2,
                            OP_RINGSET = 2'd3} tlb_op_e;
  typedef enum logic [1:0] {ACC_READ = 2'd0, ACC_WRITE = 2'd1, ACC_EXEC = 2'd2} tlb_acc_e;

  typedef struct packed {
    logic [VA_W-1:0]   vpn;
    logic [VA_W-1:0]   ppn;
    logic [ASID_W-1:0] asid;
    logic [ATTR_W-1:0] attr;
  } tlb_entry_t;

  typedef struct packed {
    logic       found;
    logic [1:0] ring;
  } ring_hit_t;

  function automatic logic [VA_W-1:0] way_mask(input int way, input logic [1:0] sz);
    if (way < 4)       return 32'hFFFF_F000;
    else if (way == 4) return 32'hFFF0_0000 << (2 * sz);
    else if (way == 5) return 32'hF800_0000;
    else               return 32'hF000_0000;
  endfunction

  function automatic logic [IDX_W-1:0] way_index(input int way, input logic [VA_W-1:0] va,
                                                 input logic [1:0] sz, input logic big);
    logic [VA_W-1:0] sh;
    sh = va >> (20 + 2 * sz);
    if (way < 4)       return big ? va[14:12] : {1'b0, va[13:12]};
    else if (way == 4) return {1'b0, sh[1:0]};
    else if (way == 5) return {2'b00, va[27]};
    else               return {2'b00, va[28]};
  endfunction

  function automatic tlb_entry_t reset_entry(input int way, input int e);
    tlb_entry_t r;
    r = '0;
    if (way == 5) begin
      r.vpn  = (e == 0) ? 32'hD000_0000 : 32'hD800_0000;
      r.ppn  = 32'h0;
      r.asid = 8'd1;
      r.attr = (e == 0) ? 4'd7 : 4'd3;
    end else if (way == 6) begin
      r.vpn  = (e == 0) ? 32'hE000_0000 : 32'hF000_0000;
      r.ppn  = 32'hF000_0000;
      r.asid = 8'd1;
      r.attr = (e == 0) ? 4'd7 : 4'd3;
    end
    return r;
  endfunction

  // Lowest byte position holding the tag wins.
  function automatic ring_hit_t asid_ring(input logic [VA_W-1:0] rr, input logic [ASID_W-1:0] asid);
    ring_hit_t r;
    r = '0;
    for (int i = 3; i >= 0; i--) begin
      if (rr[8*i +: 8] == asid) begin
        r.found = 1'b1;
        r.ring  = 2'(i);
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/tlb_ring_reg.sv
module tlb_ring_reg (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [23:0] wr_hi,
  output logic [31:0] ring_asid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ring_asid <= 32'h0403_0201;
    else if (wr_en) ring_asid <= {wr_hi, 8'h01};
  end
endmodule

// File: rtl/tlb_perm_dec.sv
module tlb_perm_dec (
  input  logic [3:0] attr,
  output logic       can_r,
  output logic       can_w,
  output logic       can_x,
  output logic       iso
);
  always_comb begin
    can_r = 1'b0;
    can_w = 1'b0;
    can_x = 1'b0;
    iso   = 1'b0;
    if (attr < 4'd12) begin
      can_r = 1'b1;
      can_w = attr[1];
      can_x = attr[0];
    end else if (attr == 4'd13) begin
      can_r = 1'b1;
      can_w = 1'b1;
      iso   = 1'b1;
    end
  end
endmodule

// File: rtl/tlb_way.sv
module tlb_way
  import tlb_pkg::*;
#(
  parameter int WAY       = 0,
  parameter bit REFILL_32 = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_size,
  input  logic [VA_W-1:0]   lk_va,
  input  logic              upd_en,
  input  logic              inv_en,
  input  logic [VA_W-1:0]   cmd_va,
  input  logic [VA_W-1:0]   cmd_pte,
  input  logic [ASID_W-1:0] wr_asid,
  output logic              lk_match,
  output logic [ASID_W-1:0] lk_asid,
  output logic [VA_W-1:0]   lk_ppn,
  output logic [ATTR_W-1:0] lk_attr,
  output logic [VA_W-1:0]   lk_mask,
  output tlb_entry_t        rd_ent
);
  localparam bit FIXED = (WAY >= 5);
  localparam int NENT  = (WAY < 4) ? (REFILL_32 ? 8 : 4) : ((WAY == 4) ? 4 : 2);
  localparam int NW    = $clog2(NENT);

  tlb_entry_t       mem [NENT];
  logic [VA_W-1:0]  mask;
  logic [IDX_W-1:0] lk_idx;
  logic [IDX_W-1:0] cmd_idx;
  logic [NW-1:0]    lk_sel;
  logic [NW-1:0]    cmd_sel;
  tlb_entry_t       lk_ent;
  tlb_entry_t       new_ent;

  assign mask    = way_mask(WAY, cfg_size);
  assign lk_idx  = way_index(WAY, lk_va, cfg_size, REFILL_32);
  assign cmd_idx = way_index(WAY, cmd_va, cfg_size, REFILL_32);
  assign lk_sel  = lk_idx[NW-1:0];
  assign cmd_sel = cmd_idx[NW-1:0];

  assign lk_ent   = mem[lk_sel];
  assign lk_match = (lk_ent.asid != '0) && (lk_ent.vpn == (lk_va & mask));
  assign lk_asid  = lk_ent.asid;
  assign lk_ppn   = lk_ent.ppn;
  assign lk_attr  = lk_ent.attr;
  assign lk_mask  = mask;
  assign rd_ent   = mem[cmd_sel];

  always_comb begin
    new_ent.vpn  = cmd_va & mask;
    new_ent.ppn  = cmd_pte & mask;
    new_ent.asid = wr_asid;
    new_ent.attr = cmd_pte[ATTR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < NENT; e++) mem[e] <= reset_entry(WAY, e);
    end else if (!FIXED) begin
      if (upd_en)      mem[cmd_sel]      <= new_ent;
      else if (inv_en) mem[cmd_sel].asid <= '0;
    end
  end
endmodule

// File: rtl/tlb_mmu.sv
module tlb_mmu
  import tlb_pkg::*;
#(
  parameter bit REFILL_32 = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  cfg_way4_size,
  input  logic [31:0] lk_vaddr,
  input  logic [1:0]  lk_cur_ring,
  input  logic [1:0]  lk_access,
  output logic [1:0]  lk_result,
  output logic [2:0]  lk_fault,
  output logic [1:0]  lk_ring,
  output logic [31:0] lk_paddr,
  output logic        lk_perm_r,
  output logic        lk_perm_w,
  output logic        lk_perm_x,
  output logic        lk_isolate,
  input  logic        cmd_valid,
  input  logic [1:0]  cmd_op,
  input  logic [31:0] cmd_addr,
  input  logic [31:0] cmd_data,
  output logic        rd_valid,
  output logic [31:0] rd_tag,
  output logic [31:0] rd_word,
  output logic [31:0] ring_asid
);
  logic [NUM_WAYS-1:0] way_match;
  logic [NUM_WAYS-1:0] way_hit;
  logic [ASID_W-1:0]   w_asid [NUM_WAYS];
  logic [VA_W-1:0]     w_ppn  [NUM_WAYS];
  logic [ATTR_W-1:0]   w_attr [NUM_WAYS];
  logic [VA_W-1:0]     w_mask [NUM_WAYS];
  tlb_entry_t          w_rd   [NUM_WAYS];
  ring_hit_t           w_ring [NUM_WAYS];

  logic [2:0]        cmd_way;
  logic [ASID_W-1:0] wr_asid;
  logic              do_write, do_inval, do_read, do_ring;

  assign cmd_way  = cmd_addr[2:0];
  assign wr_asid  = ring_asid[8*cmd_data[5:4] +: 8];
  assign do_write = cmd_valid && (cmd_op == OP_WRITE);
  assign do_inval = cmd_valid && (cmd_op == OP_INVAL);
  assign do_read  = cmd_valid && (cmd_op == OP_READ);
  assign do_ring  = cmd_valid && (cmd_op == OP_RINGSET);

  tlb_ring_reg u_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (do_ring),
    .wr_hi     (cmd_data[31:8]),
    .ring_asid (ring_asid)
  );

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    tlb_way #(.WAY(w), .REFILL_32(REFILL_32)) u_way (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_size (cfg_way4_size),
      .lk_va    (lk_vaddr),
      .upd_en   (do_write && (cmd_way == 3'(w))),
      .inv_en   (do_inval && (cmd_way == 3'(w))),
      .cmd_va   (cmd_addr),
      .cmd_pte  (cmd_data),
      .wr_asid  (wr_asid),
      .lk_match (way_match[w]),
      .lk_asid  (w_asid[w]),
      .lk_ppn   (w_ppn[w]),
      .lk_attr  (w_attr[w]),
      .lk_mask  (w_mask[w]),
      .rd_ent   (w_rd[w])
    );
    assign w_ring[w]  = asid_ring(ring_asid, w_asid[w]);
    assign way_hit[w] = way_match[w] && w_ring[w].found;
  end

  // Select the hitting way (lowest index when several hit; only used on single hit).
  logic [VA_W-1:0]   sel_ppn;
  logic [VA_W-1:0]   sel_mask;
  logic [ATTR_W-1:0] sel_attr;
  logic [1:0]        sel_ring;
  always_comb begin
    sel_ppn  = '0;
    sel_mask = '1;
    sel_attr = '0;
    sel_ring = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (way_hit[w]) begin
        sel_ppn  = w_ppn[w];
        sel_mask = w_mask[w];
        sel_attr = w_attr[w];
        sel_ring = w_ring[w].ring;
      end
    end
  end

  logic can_r, can_w, can_x, iso;
  tlb_perm_dec u_perm (
    .attr  (sel_attr),
    .can_r (can_r),
    .can_w (can_w),
    .can_x (can_x),
    .iso   (iso)
  );

  logic granted;
  always_comb begin
    case (lk_access)
      ACC_READ:  granted = can_r;
      ACC_WRITE: granted = can_w;
      ACC_EXEC:  granted = can_x;
      default:   granted = 1'b0;
    endcase
  end

  logic [3:0] hit_cnt;
  assign hit_cnt = 4'($countones(way_hit));

  always_comb begin
    lk_result  = RES_MISS;
    lk_fault   = FLT_MISS;
    lk_ring    = '0;
    lk_paddr   = '0;
    lk_perm_r  = 1'b0;
    lk_perm_w  = 1'b0;
    lk_perm_x  = 1'b0;
    lk_isolate = 1'b0;
    if (hit_cnt > 4'd1) begin
      lk_result = RES_MULTI;
      lk_fault  = FLT_MULTI;
    end else if (hit_cnt == 4'd1) begin
      lk_result  = RES_HIT;
      lk_ring    = sel_ring;
      lk_paddr   = sel_ppn | (lk_vaddr & ~sel_mask);
      lk_perm_r  = can_r;
      lk_perm_w  = can_w;
      lk_perm_x  = can_x;
      lk_isolate = iso;
      if (sel_ring < lk_cur_ring) lk_fault = FLT_PRIV;
      else if (!granted)          lk_fault = FLT_PROHIB;
      else                        lk_fault = FLT_NONE;
    end
  end

  // Read-back port
  tlb_entry_t rd_sel;
  always_comb begin
    rd_sel = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (cmd_way == 3'(w)) rd_sel = w_rd[w];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_tag   <= '0;
      rd_word  <= '0;
    end else begin
      rd_valid <= do_read;
      if (do_read) begin
        rd_tag  <= rd_sel.vpn | {{(VA_W-ASID_W){1'b0}}, rd_sel.asid};
        rd_word <= rd_sel.ppn | {{(VA_W-ATTR_W){1'b0}}, rd_sel.attr};
      end
    end
  end
endmodule

// File: rtl/tlb_mmu_chk.sv
module tlb_mmu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [11:0] va_lo,
  input logic [11:0] pa_lo,
  input logic [1:0]  lk_cur_ring,
  input logic [1:0]  lk_access,
  input logic [1:0]  lk_result,
  input logic [2:0]  lk_fault,
  input logic [1:0]  lk_ring,
  input logic        lk_perm_r,
  input logic        lk_perm_w,
  input logic        lk_perm_x,
  input logic        cmd_valid,
  input logic [1:0]  cmd_op,
  input logic [23:0] data_hi,
  input logic        rd_valid,
  input logic [31:0] ring_asid
);
  logic acc_ok;
  assign acc_ok = (lk_access == 2'd0 && lk_perm_r) || (lk_access == 2'd1 && lk_perm_w) ||
                  (lk_access == 2'd2 && lk_perm_x);

  a_r2_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
    ring_asid[7:0] == 8'h01);
  a_r2_ring_load: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd3) |=> ring_asid == {$past(data_hi), 8'h01});
  a_r6_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_result == 2'd0) |-> (pa_lo == va_lo));
  a_r4_nohit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_result != 2'd0) |-> ((lk_fault == 3'd1 || lk_fault == 3'd2) &&
                             !lk_perm_r && !lk_perm_w && !lk_perm_x && lk_ring == 2'd0));
  a_r7_priv_order: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_fault == 3'd3) |-> (lk_result == 2'd0 && lk_ring < lk_cur_ring));
  a_r7_prohib_order: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_fault == 3'd4) |-> (lk_result == 2'd0 && lk_ring >= lk_cur_ring && !acc_ok));
  a_r8_write_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    lk_perm_w |-> lk_perm_r);
  a_r11_read_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd2) |=> rd_valid);
  a_r11_no_stray: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_op == 2'd2) |=> !rd_valid);
endmodule

bind tlb_mmu tlb_mmu_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .va_lo       (lk_vaddr[11:0]),
  .pa_lo       (lk_paddr[11:0]),
  .lk_cur_ring (lk_cur_ring),
  .lk_access   (lk_access),
  .lk_result   (lk_result),
  .lk_fault    (lk_fault),
  .lk_ring     (lk_ring),
  .lk_perm_r   (lk_perm_r),
  .lk_perm_w   (lk_perm_w),
  .lk_perm_x   (lk_perm_x),
  .cmd_valid   (cmd_valid),
  .cmd_op      (cmd_op),
  .data_hi     (cmd_data[31:8]),
  .rd_valid    (rd_valid),
  .ring_asid   (ring_asid)
);

// File: tb/tlb_mmu_tb.sv
`timescale 1ns/1ps
module tlb_mmu_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [1:0]  cfg_way4_size = 2'd0;
  logic [31:0] lk_vaddr = '0;
  logic [1:0]  lk_cur_ring = '0;
  logic [1:0]  lk_access = '0;
  logic [1:0]  lk_result;
  logic [2:0]  lk_fault;
  logic [1:0]  lk_ring;
  logic [31:0] lk_paddr;
  logic        lk_perm_r, lk_perm_w, lk_perm_x, lk_isolate;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = '0;
  logic [31:0] cmd_addr = '0;
  logic [31:0] cmd_data = '0;
  logic        rd_valid;
  logic [31:0] rd_tag, rd_word, ring_asid;

  tlb_mmu u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_way4_size(cfg_way4_size),
    .lk_vaddr(lk_vaddr), .lk_cur_ring(lk_cur_ring), .lk_access(lk_access),
    .lk_result(lk_result), .lk_fault(lk_fault), .lk_ring(lk_ring), .lk_paddr(lk_paddr),
    .lk_perm_r(lk_perm_r), .lk_perm_w(lk_perm_w), .lk_perm_x(lk_perm_x),
    .lk_isolate(lk_isolate), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .rd_valid(rd_valid),
    .rd_tag(rd_tag), .rd_word(rd_word), .ring_asid(ring_asid)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // Reference model
  logic [31:0] m_vpn  [0:6][0:7];
  logic [31:0] m_ppn  [0:6][0:7];
  logic [7:0]  m_asid [0:6][0:7];
  logic [3:0]  m_attr [0:6][0:7];
  logic [31:0] m_ring;

  function automatic logic [31:0] bmask(input int w, input logic [1:0] sz);
    if (w < 4) return 32'hFFFFF000;
    if (w == 4) return 32'hFFF00000 << (2 * sz);
    if (w == 5) return 32'hF8000000;
    return 32'hF0000000;
  endfunction

  function automatic int bidx(input int w, input logic [31:0] va, input logic [1:0] sz);
    logic [31:0] s;
    s = va >> (20 + 2 * sz);
    if (w < 4) return int'(va[13:12]);
    if (w == 4) return int'(s[1:0]);
    if (w == 5) return int'(va[27]);
    return int'(va[28]);
  endfunction

  task automatic model_reset();
    for (int w = 0; w < 7; w++)
      for (int e = 0; e < 8; e++) begin
        m_vpn[w][e] = '0; m_ppn[w][e] = '0; m_asid[w][e] = '0; m_attr[w][e] = '0;
      end
    m_vpn[5][0] = 32'hD0000000; m_attr[5][0] = 4'd7; m_asid[5][0] = 8'd1;
    m_vpn[5][1] = 32'hD8000000; m_attr[5][1] = 4'd3; m_asid[5][1] = 8'd1;
    m_vpn[6][0] = 32'hE0000000; m_ppn[6][0] = 32'hF0000000; m_attr[6][0] = 4'd7; m_asid[6][0] = 8'd1;
    m_vpn[6][1] = 32'hF0000000; m_ppn[6][1] = 32'hF0000000; m_attr[6][1] = 4'd3; m_asid[6][1] = 8'd1;
    m_ring = 32'h04030201;
  endtask

  function automatic logic [43:0] model_lookup(input logic [31:0] va, input logic [1:0] cr,
                                               input logic [1:0] acc, input logic [1:0] sz);
    int cnt; int hw; int he; logic [1:0] hr;
    logic r, w, x, iso, ok; logic [2:0] f; logic [31:0] pa; logic [3:0] a;
    cnt = 0; hw = 0; he = 0; hr = 0;
    for (int wy = 0; wy < 7; wy++) begin
      int e; int rg;
      e = bidx(wy, va, sz);
      rg = -1;
      for (int b = 3; b >= 0; b--) if (m_ring[8*b +: 8] == m_asid[wy][e]) rg = b;
      if (m_asid[wy][e] != 0 && m_vpn[wy][e] == (va & bmask(wy, sz)) && rg >= 0) begin
        if (cnt == 0) begin hw = wy; he = e; hr = 2'(rg); end
        cnt++;
      end
    end
    if (cnt == 0) return {2'd1, 3'd1, 2'd0, 32'd0, 4'd0};
    if (cnt > 1)  return {2'd2, 3'd2, 2'd0, 32'd0, 4'd0};
    a = m_attr[hw][he];
    r = 0; w = 0; x = 0; iso = 0;
    if (a < 12) begin r = 1; w = a[1]; x = a[0]; end
    else if (a == 13) begin r = 1; w = 1; iso = 1; end
    ok = (acc == 0) ? r : (acc == 1) ? w : (acc == 2) ? x : 1'b0;
    f = (hr < cr) ? 3'd3 : (!ok ? 3'd4 : 3'd0);
    pa = m_ppn[hw][he] | (va & ~bmask(hw, sz));
    return {2'd0, f, hr, pa, r, w, x, iso};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic look(input logic [31:0] va, input logic [1:0] cr, input logic [1:0] acc,
                      input string req);
    logic [43:0] exp, act;
    @(negedge clk);
    lk_vaddr = va; lk_cur_ring = cr; lk_access = acc;
    #1;
    exp = model_lookup(va, cr, acc, cfg_way4_size);
    act = {lk_result, lk_fault, lk_ring, lk_paddr, lk_perm_r, lk_perm_w, lk_perm_x, lk_isolate};
    check(act === exp, req, 64'(act), 64'(exp));
  endtask

  task automatic do_cmd(input logic [1:0] op, input logic [31:0] a, input logic [31:0] d,
                        input string req);
    int w; int e; logic [31:0] et, ew;
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_addr = a; cmd_data = d;
    w = int'(a[2:0]);
    et = '0; ew = '0;
    if (w < 7) begin
      e = bidx(w, a, cfg_way4_size);
      et = m_vpn[w][e] | {24'd0, m_asid[w][e]};
      ew = m_ppn[w][e] | {28'd0, m_attr[w][e]};
    end
    @(posedge clk);
    #1;
    if (w < 5 && op == 2'd0) begin
      e = bidx(w, a, cfg_way4_size);
      m_vpn[w][e]  = a & bmask(w, cfg_way4_size);
      m_ppn[w][e]  = d & bmask(w, cfg_way4_size);
      m_asid[w][e] = m_ring[8*d[5:4] +: 8];
      m_attr[w][e] = d[3:0];
    end else if (w < 5 && op == 2'd1) begin
      e = bidx(w, a, cfg_way4_size);
      m_asid[w][e] = '0;
    end else if (op == 2'd3) begin
      m_ring = {d[31:8], 8'h01};
    end
    @(negedge clk);
    cmd_valid = 0;
    if (op == 2'd2)
      check(rd_valid === 1'b1 && rd_tag === et && rd_word === ew, req,
            {rd_valid, rd_tag[30:0], rd_word}, {1'b1, et[30:0], ew});
    if (op == 2'd3)
      check(ring_asid === m_ring, req, 64'(ring_asid), 64'(m_ring));
  endtask

  function automatic logic [31:0] rnd_va();
    logic [31:0] pool [5];
    pool[0] = 32'h00000000; pool[1] = 32'h00300000; pool[2] = 32'h40000000;
    pool[3] = 32'hD0000000; pool[4] = 32'hE8000000;
    return pool[$urandom % 5] + ($urandom & 32'h0000FFFF);
  endfunction

  initial begin
    #2_000_000;
    if (!finished) begin
      n_bad++; n_vec++;
      $display("FAIL watchdog timeout actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    // R1: reset state
    check(ring_asid === 32'h04030201, "R1 ring reset", 64'(ring_asid), 64'h04030201);
    check(rd_valid === 1'b0, "R11 idle strobe", 64'(rd_valid), 64'd0);
    look(32'h00001000, 2'd0, 2'd0, "R1 miss after reset");
    // R12 R6: fixed windows
    look(32'hD0001234, 2'd0, 2'd0, "R12 R6 way5 entry0");
    look(32'hDC000040, 2'd0, 2'd1, "R12 R8 way5 entry1 write");
    look(32'hE8000010, 2'd0, 2'd2, "R12 R6 way6 entry0");
    look(32'hF0001000, 2'd0, 2'd1, "R12 way6 entry1");
    // R9 R3: refill write, tag from ring byte 2 -> ring 2
    do_cmd(2'd0, 32'h00003001, 32'h12345024, "R9 write way1");
    look(32'h00003ABC, 2'd2, 2'd0, "R3 R9 hit ring2");
    look(32'h00003ABC, 2'd3, 2'd0, "R7 privilege fault");
    look(32'h00003ABC, 2'd2, 2'd2, "R8 R7 exec prohibited");
    look(32'h00002ABC, 2'd0, 2'd0, "R5 other refill index misses");
    // R2: ring register load, tag 3 disappears
    do_cmd(2'd3, 32'h0, 32'h05060700, "R2 ring load low byte forced");
    look(32'h00003ABC, 2'd0, 2'd0, "R3 tag absent from ring register");
    do_cmd(2'd3, 32'h0, 32'h04030200, "R2 ring restore");
    // R4: multi-hit via way4
    do_cmd(2'd0, 32'h00000004, 32'h20000000, "R9 write way4");
    look(32'h00003ABC, 2'd0, 2'd0, "R4 multi-hit");
    // R10: invalidate way1
    do_cmd(2'd1, 32'h00003001, 32'h0, "R10 invalidate way1");
    look(32'h00003ABC, 2'd0, 2'd0, "R10 R6 way4 only after invalidate");
    look(32'h00003ABC, 2'd0, 2'd1, "R8 attr0 write prohibited");
    // R9 R10: fixed ways ignore maintenance
    do_cmd(2'd0, 32'hD0000005, 32'h7770000F, "R9 write fixed way5");
    do_cmd(2'd1, 32'hE0000006, 32'h0, "R10 invalidate fixed way6");
    look(32'hD0001234, 2'd0, 2'd0, "R9 fixed way5 unchanged");
    look(32'hE0000044, 2'd0, 2'd0, "R10 fixed way6 unchanged");
    // R5: way4 page size change
    cfg_way4_size = 2'd1;
    look(32'h00250000, 2'd0, 2'd0, "R5 way4 4MB page");
    cfg_way4_size = 2'd0;
    look(32'h00250000, 2'd0, 2'd0, "R5 way4 back to 1MB");
    // R11: read back
    do_cmd(2'd2, 32'h00000004, 32'h0, "R11 read way4");
    do_cmd(2'd2, 32'h08000005, 32'h0, "R11 R12 read way5 entry1");
    do_cmd(2'd2, 32'h00000007, 32'h0, "R11 read way7 zero");
    // R8: isolate and invalid attributes
    do_cmd(2'd0, 32'h00042002, 32'h3000000D, "R9 write attr13");
    look(32'h00042FFF, 2'd0, 2'd1, "R8 attr13 write ok isolate");
    look(32'h00042FFF, 2'd0, 2'd2, "R8 attr13 exec prohibited");
    do_cmd(2'd0, 32'h00042002, 32'h3000000E, "R9 write attr14");
    look(32'h00042FFF, 2'd0, 2'd0, "R8 attr14 read prohibited");
    look(32'h00042FFF, 2'd0, 2'd3, "R8 access code 3 denied");

    // Random mix
    for (int i = 0; i < 1500; i++) begin
      int k;
      k = $urandom % 10;
      if (k < 4) look(rnd_va(), 2'($urandom), 2'($urandom), "R3 R4 R6 R7 R8 random lookup");
      else if (k < 7) do_cmd(2'd0, (rnd_va() & 32'hFFFFFFF8) | ($urandom % 8),
                             $urandom & 32'hFFFFF03F, "R9 random write");
      else if (k == 7) do_cmd(2'd1, (rnd_va() & 32'hFFFFFFF8) | ($urandom % 8), 32'h0,
                              "R10 random invalidate");
      else if (k == 8) do_cmd(2'd2, (rnd_va() & 32'hFFFFFFF8) | ($urandom % 8), 32'h0,
                              "R11 random read");
      else if ($urandom % 2)
        do_cmd(2'd3, 32'h0, {8'($urandom % 6), 8'($urandom % 6), 8'($urandom % 6), 8'h00},
               "R2 random ring load");
      else begin
        @(negedge clk);
        cfg_way4_size = 2'($urandom);
      end
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule